// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

This block gathers level-sensitive interrupt request lines from peripherals and presents one active-high request line to a processor core, along with a 6-bit number that names the most urgent request currently raised. Numbers 0 to 15 are reserved and have no input. The 48 request inputs map to numbers 16 through 63. A lower number has higher priority.

The block also decides whether the core takes the request. It takes a request only when the global enable input is high and the displayed number is no greater than a programmable priority threshold. An accepted request appears as a one-cycle pulse with the captured number held next to it. No further request is taken until software returns an acknowledge strobe, which stands in for the core turning interrupts off when it enters an exception. The block never clears a request by itself. A peripheral holds its line until software services it.

Top module: `irq_prio_arb`

## Requirements
- R1: Each request input passes through two synchronizer flops, and `irq`/`irq_num` are registered. A change on `req_in` driven before a rising edge shows on `irq`/`irq_num` after the third rising edge and not before.
- R2: When several requests are raised, `irq_num` names the one with the lowest number. Input bit i carries number i+16.
- R3: Only numbers 16 to 63 can be presented. Whenever `irq` is 1, `irq_num` is at least 16.
- R4: When no request is raised, `irq` is 0 and `irq_num` is 63.
- R5: A request is taken when `int_en` is 1 and `irq_num` is less than or equal to `pri_thresh`. A number equal to the threshold is taken.
- R6: A number one above the threshold is not taken. With `int_en` at 0, no request is taken, whatever the threshold.
- R7: `take_exc` is a one-cycle pulse. It rises one cycle after the `irq`/`irq_num` it accepts, and `take_num` holds that number from then on.
- R8: After a take, no further take occurs until `ack` is pulsed. A request still raised after the `ack` is taken again.
- R9: The block never drops a request by itself. `irq_num` follows the raised inputs, moving to a more urgent request when one arrives and back to the pending one when it leaves.
- R10: After reset, `irq` and `take_exc` are 0 and `irq_num` and `take_num` are 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 48 | Level request lines; bit i is number i+16 |
| int_en | input | 1 | Global acceptance enable |
| pri_thresh | input | 6 | Largest number that may be taken |
| ack | input | 1 | Software acknowledge strobe; reopens acceptance |
| irq | output | 1 | Any request raised (registered) |
| irq_num | output | 6 | Most urgent raised number, 63 when idle |
| take_exc | output | 1 | One-cycle acceptance pulse |
| take_num | output | 6 | Number captured at the last acceptance |

## Verification
The hardest case to reach from the ports is a request that stays raised across an acceptance, while the block must withhold a second take until `ack` and then take the same request again. A related case is a more urgent request arriving and leaving while a less urgent one waits. Directed sequences hold one line high through a take, count `take_exc` pulses over a long window, then pulse `ack` and expect exactly one more. A second sequence overlays and then removes a lower-numbered line and checks that the displayed number returns to the waiting one.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_W     = 6;
  localparam int FIRST_SRC = 16;
  localparam int NUM_SRC   = (1 << NUM_W) - FIRST_SRC;
  typedef logic [NUM_W-1:0] irq_num_t;
  localparam irq_num_t IDLE_NUM = irq_num_t'((1 << NUM_W) - 1);
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output irq_num_t           num
);
  always_comb begin
    any = 1'b0;
    num = IDLE_NUM;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        num = irq_num_t'(i + FIRST_SRC);
      end
    end
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     irq,
  input  irq_num_t irq_num,
  input  logic     int_en,
  input  irq_num_t pri_thresh,
  input  logic     ack,
  output logic     take_exc,
  output irq_num_t take_num
);
  logic busy;
  logic take;

  assign take = irq && int_en && (irq_num <= pri_thresh) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      take_exc <= 1'b0;
      take_num <= IDLE_NUM;
    end else begin
      take_exc <= take;
      if (take) begin
        busy     <= 1'b1;
        take_num <= irq_num;
      end else if (ack) begin
        busy <= 1'b0;
      end
    end
  end

  // R8: a held acceptance blocks the next pulse
  p_no_take_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !take_exc);
  // R7: single-cycle pulse
  p_take_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    take_exc |=> !take_exc);
  // R5, R6: acceptance gated by enable and threshold
  p_take_gated_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(take_exc) |-> ($past(int_en) && ($past(irq_num) <= $past(pri_thresh))));
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic               int_en,
  input  logic [NUM_W-1:0]   pri_thresh,
  input  logic               ack,
  output logic               irq,
  output logic [NUM_W-1:0]   irq_num,
  output logic               take_exc,
  output logic [NUM_W-1:0]   take_num
);
  logic [NUM_SRC-1:0] req_s;
  logic               any_c;
  irq_num_t           num_c;

  irq_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rst(rst), .d(req_in), .q(req_s)
  );

  irq_prio_enc u_enc (
    .req(req_s), .any(any_c), .num(num_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      irq_num <= IDLE_NUM;
    end else begin
      irq     <= any_c;
      irq_num <= num_c;
    end
  end

  irq_accept u_acc (
    .clk(clk), .rst(rst), .irq(irq), .irq_num(irq_num),
    .int_en(int_en), .pri_thresh(pri_thresh), .ack(ack),
    .take_exc(take_exc), .take_num(take_num)
  );

  // R4: idle shows the lowest-priority number
  p_idle_num_r4: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (irq_num == IDLE_NUM));
  // R3: reserved numbers never presented
  p_no_reserved_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_num >= irq_num_t'(FIRST_SRC)));
endmodule

// File: tb/tb_irq_prio_arb.sv
module tb_irq_prio_arb;
  localparam int NS = 48;

  typedef struct packed {
    logic [NS-1:0] req;
    logic          ie;
    logic [5:0]    thr;
    logic          e_irq;
    logic [5:0]    e_num;
    logic          e_take;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{req: 48'(1) << 4, ie: 1'b1, thr: 6'd20, e_irq: 1'b1, e_num: 6'd20, e_take: 1'b1},
    '{req: 48'(1) << 5, ie: 1'b1, thr: 6'd20, e_irq: 1'b1, e_num: 6'd21, e_take: 1'b0},
    '{req: (48'(1) << 0) | (48'(1) << 24), ie: 1'b0, thr: 6'd63, e_irq: 1'b1, e_num: 6'd16, e_take: 1'b0},
    '{req: 48'(0), ie: 1'b1, thr: 6'd63, e_irq: 1'b0, e_num: 6'd63, e_take: 1'b0},
    '{req: 48'(1) << 47, ie: 1'b1, thr: 6'd63, e_irq: 1'b1, e_num: 6'd63, e_take: 1'b1},
    '{req: (48'(1) << 14) | (48'(1) << 29) | (48'(1) << 34), ie: 1'b1, thr: 6'd63, e_irq: 1'b1, e_num: 6'd30, e_take: 1'b1},
    '{req: 48'(1) << 0, ie: 1'b1, thr: 6'd15, e_irq: 1'b1, e_num: 6'd16, e_take: 1'b0},
    '{req: {NS{1'b1}}, ie: 1'b1, thr: 6'd16, e_irq: 1'b1, e_num: 6'd16, e_take: 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] req_in = '0;
  logic int_en = 1'b0;
  logic [5:0] pri_thresh = 6'd0;
  logic ack = 1'b0;
  logic irq, take_exc;
  logic [5:0] irq_num, take_num;

  int checks = 0;
  int fails = 0;
  int takes = 0;

  always #2.5 clk = ~clk;

  irq_prio_arb dut (
    .clk(clk), .rst(rst), .req_in(req_in), .int_en(int_en),
    .pri_thresh(pri_thresh), .ack(ack), .irq(irq), .irq_num(irq_num),
    .take_exc(take_exc), .take_num(take_num)
  );

  always @(negedge clk) if (take_exc) takes++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; cyc(1); ack = 1'b0;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    // R10: reset state
    chk("R10 irq", irq, 0);
    chk("R10 irq_num", irq_num, 63);
    chk("R10 take_exc", take_exc, 0);
    chk("R10 take_num", take_num, 63);
    rst = 1'b0;
    cyc(1);

    for (int v = 0; v < NV; v++) begin
      req_in = '0; cyc(4); pulse_ack(); takes = 0;
      int_en = VECS[v].ie; pri_thresh = VECS[v].thr; req_in = VECS[v].req;
      cyc(8);
      chk("R2/R3/R4 irq", irq, VECS[v].e_irq);
      chk("R2/R3/R4 irq_num", irq_num, VECS[v].e_num);
      chk("R5/R6 take count", takes, VECS[v].e_take ? 1 : 0);
      if (VECS[v].e_take) chk("R7 take_num", take_num, VECS[v].e_num);
    end

    // R1: latency from idle
    req_in = '0; int_en = 1'b0; cyc(4); pulse_ack();
    req_in = 48'(1) << 17;
    cyc(2);
    chk("R1 irq after 2 edges", irq, 0);
    cyc(1);
    chk("R1 irq after 3 edges", irq, 1);
    chk("R1 irq_num", irq_num, 33);

    // R9: preemption and fall back, with acceptance off
    req_in = 48'(1) << 24; cyc(5);
    chk("R9 pending num", irq_num, 40);
    req_in = (48'(1) << 24) | (48'(1) << 9); cyc(5);
    chk("R9 preempt num", irq_num, 25);
    req_in = 48'(1) << 24; cyc(5);
    chk("R9 fall back num", irq_num, 40);
    chk("R9 still raised", irq, 1);

    // R7/R8: held request, single take until ack
    takes = 0; int_en = 1'b1; pri_thresh = 6'd63;
    cyc(1);
    chk("R7 pulse on take cycle", take_exc, 1);
    cyc(1);
    chk("R7 pulse ends", take_exc, 0);
    cyc(20);
    chk("R8 single take while held", takes, 1);
    chk("R7 take_num held", take_num, 40);
    pulse_ack(); cyc(4);
    chk("R8 retaken after ack", takes, 2);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule